// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Math Block

This block is the arithmetic tile of a filter or neural-network datapath. Each cycle it takes three 18-bit operands (A, B and a pre-add operand D), optionally adds D to A, multiplies the result by B and folds the product into a 48-bit accumulator. Two-bit mode selects how the 18-bit operands are used:
- full precision: one 18x18 product.
- dual: two independent 9x9 products, each in its own half of the result.
- dot: two 9x9 products summed inside the block.

The pre-adder keeps its carry in every mode. It gives 19 bits at full precision and 10 bits per lane in the 9-bit modes, so symmetric filter taps need no outside adder.

The block has three register stages: operand capture, product, and accumulator. A cascade output carries the captured A operand to the next block in a chain. A cascade input can replace the A port, so a row of blocks forms a systolic filter with no fabric registers between them. A load control restarts the accumulator from the current product. An accumulate enable of zero freezes the accumulator.

Top module: `mac_block`

## Requirements
- R1: While `rst_n` is low at a rising edge, every pipeline register is cleared, and `result` and `casc_out` read zero afterwards.
- R2: With `mode` = 0, `result` is the 48-bit two's-complement sum of signed A×B products, added once per cycle while `acc_en` = 1.
- R3: With `pre_en` = 1 in mode 0, the multiplier input is the signed 19-bit sum A+D with no truncation. With `pre_en` = 0 it is A alone.
- R4: `casc_out` equals the selected A operand one rising edge later. When `casc_sel` = 1, `casc_in` replaces `op_a` as the A operand.
- R5: With `mode` = 1, `result[23:0]` holds the signed product A[8:0]×B[8:0] and `result[47:24]` holds A[17:9]×B[17:9]. Each product is sign-extended to 24 bits.
- R6: In mode 1, the two 24-bit halves accumulate separately. A carry out of bit 23 never reaches bit 24.
- R7: With `mode` = 2, `result` accumulates the sign-extended sum of the two 9x9 lane products.
- R8: In modes 1 and 2 with `pre_en` = 1, each lane multiplies the signed 10-bit sum of its own A and D 9-bit fields by its B field.
- R9: `load` = 1 replaces the accumulator with the current product. It takes precedence over `acc_en`.
- R10: With `load` = 0 and `acc_en` = 0, the accumulator keeps its value.
- R11: The 48-bit accumulator wraps modulo 2^48 on overflow, with no saturation.
- R12: Operands and controls present before rising edge k affect `result` just after edge k+2. This is the third edge that samples them.
- R13: Mode code 3 behaves as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 full 18x18, 1 dual 9x9, 2 dot product, 3 as 0 |
| pre_en | input | 1 | Use A+D instead of A as multiplier input |
| acc_en | input | 1 | Add product into accumulator |
| load | input | 1 | Replace accumulator with product |
| casc_sel | input | 1 | Take A operand from `casc_in` |
| op_a | input | 18 | Operand A (lanes: [8:0], [17:9]) |
| op_b | input | 18 | Operand B (lanes: [8:0], [17:9]) |
| op_d | input | 18 | Pre-add operand D (lanes: [8:0], [17:9]) |
| casc_in | input | 18 | A operand from the previous block |
| result | output | 48 | Accumulator value |
| casc_out | output | 18 | Captured A operand for the next block |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge. They also assume that `rst_n` is low for at least one edge before any other check counts. The stimulus changes inputs only on falling edges and starts with a reset. Each control stays constant over the three-edge pipeline window that a check depends on, so every input the properties sample is settled.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
// mac_pkg: shared mode encoding for the multiply-accumulate block.
// Assumes a two-bit mode field; code 3 is treated as full precision.
package mac_pkg;
    typedef enum logic [1:0] {
        MODE_FULL = 2'd0,
        MODE_DUAL = 2'd1,
        MODE_DOT  = 2'd2,
        MODE_ALT  = 2'd3
    } mac_mode_e;
endpackage

// File: rtl/mac_lane.sv
`timescale 1ns/1ps
// mac_lane: optional pre-add (A+D, one guard bit) followed by a signed
// multiply by B. Purely combinational; operands are two's complement.
// Assumes the caller registers inputs and outputs.
module mac_lane #(
    parameter int W = 18
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   d,
    input  logic           pre_en,
    output logic [2*W:0]   prod
);
    localparam int PW = W + 1;
    localparam int RW = 2 * W + 1;

    logic [PW-1:0] mult_in;
    logic [RW-1:0] mult_in_x;
    logic [RW-1:0] b_x;

    // pre-adder with full carry, or bypass of A
    always_comb begin
        if (pre_en)
            mult_in = {a[W-1], a} + {d[W-1], d};
        else
            mult_in = {a[W-1], a};
    end

    // sign-extend both factors to result width, then multiply
    always_comb begin
        mult_in_x = {{(RW-PW){mult_in[PW-1]}}, mult_in};
        b_x       = {{(RW-W){b[W-1]}}, b};
        prod      = RW'($signed(mult_in_x) * $signed(b_x));
    end
endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
// mac_accum: accumulator register. Load replaces, enable adds, otherwise
// holds. In split mode the two halves add without carry between them.
// Assumes the product input is already formatted for the active mode.
module mac_accum #(
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] prod,
    input  logic             split,
    input  logic             load,
    input  logic             acc_en,
    output logic [ACC_W-1:0] acc
);
    localparam int HW = ACC_W / 2;

    logic [ACC_W-1:0] sum_whole;
    logic [HW-1:0]    sum_lo;
    logic [HW-1:0]    sum_hi;
    logic [ACC_W-1:0] sum_sel;

    // whole-width and per-half sums, picked by split
    always_comb begin
        sum_whole = acc + prod;
        sum_lo    = acc[HW-1:0] + prod[HW-1:0];
        sum_hi    = acc[ACC_W-1:HW] + prod[ACC_W-1:HW];
        sum_sel   = split ? {sum_hi, sum_lo} : sum_whole;
    end

    // accumulator update with load priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (load)
            acc <= prod;
        else if (acc_en)
            acc <= sum_sel;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> acc == $past(prod)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !acc_en) |=> $stable(acc)); // R10
    AST_NO_LANE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (split && acc_en && !load) |=>
        acc[ACC_W-1:HW] == HW'($past(acc[ACC_W-1:HW]) + $past(prod[ACC_W-1:HW]))); // R6
endmodule

// File: rtl/mac_block.sv
`timescale 1ns/1ps
// mac_block: three-stage multiply-accumulate tile with pre-adder,
// operand cascade, and full / dual-lane / dot-product modes.
// Stage 1 captures operands, stage 2 registers the formatted product,
// stage 3 is the accumulator. Assumes OP_W is even and ACC_W is large
// enough for one full-width product.
module mac_block
    import mac_pkg::*;
#(
    parameter int OP_W  = 18,
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             pre_en,
    input  logic             acc_en,
    input  logic             load,
    input  logic             casc_sel,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [OP_W-1:0]  op_d,
    input  logic [OP_W-1:0]  casc_in,
    output logic [ACC_W-1:0] result,
    output logic [OP_W-1:0]  casc_out
);
    localparam int HALF_W = OP_W / 2;
    localparam int LANE_W = ACC_W / 2;
    localparam int FP_W   = 2 * OP_W + 1;
    localparam int NP_W   = 2 * HALF_W + 1;
    localparam int NLANE  = 2;

    logic [OP_W-1:0]  a_sel;
    logic [OP_W-1:0]  a_q, b_q, d_q;
    logic [1:0]       mode_q;
    logic             pre_q, acc_q, load_q;

    logic [FP_W-1:0]  full_prod;
    logic [NP_W-1:0]  lane_prod [NLANE];
    logic [LANE_W-1:0] lane_ext [NLANE];
    logic [ACC_W-1:0] lane_wide [NLANE];
    logic [ACC_W-1:0] prod_fmt;

    logic [ACC_W-1:0] prod_q;
    logic             split_q, acc_q2, load_q2;

    // pick the A source for this block
    always_comb a_sel = casc_sel ? casc_in : op_a;

    // stage 1: capture operands and controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            d_q    <= '0;
            mode_q <= 2'd0;
            pre_q  <= 1'b0;
            acc_q  <= 1'b0;
            load_q <= 1'b0;
        end else begin
            a_q    <= a_sel;
            b_q    <= op_b;
            d_q    <= op_d;
            mode_q <= mode;
            pre_q  <= pre_en;
            acc_q  <= acc_en;
            load_q <= load;
        end
    end

    assign casc_out = a_q;

    mac_lane #(.W(OP_W)) u_full (
        .a      (a_q),
        .b      (b_q),
        .d      (d_q),
        .pre_en (pre_q),
        .prod   (full_prod)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        mac_lane #(.W(HALF_W)) u_half (
            .a      (a_q[g*HALF_W +: HALF_W]),
            .b      (b_q[g*HALF_W +: HALF_W]),
            .d      (d_q[g*HALF_W +: HALF_W]),
            .pre_en (pre_q),
            .prod   (lane_prod[g])
        );
        assign lane_ext[g]  = {{(LANE_W-NP_W){lane_prod[g][NP_W-1]}}, lane_prod[g]};
        assign lane_wide[g] = {{(ACC_W-NP_W){lane_prod[g][NP_W-1]}}, lane_prod[g]};
    end

    // format the product for the captured mode
    always_comb begin
        case (mac_mode_e'(mode_q))
            MODE_DUAL: prod_fmt = {lane_ext[1], lane_ext[0]};
            MODE_DOT:  prod_fmt = lane_wide[0] + lane_wide[1];
            default:   prod_fmt = {{(ACC_W-FP_W){full_prod[FP_W-1]}}, full_prod};
        endcase
    end

    // stage 2: register product and its accumulator controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            split_q <= 1'b0;
            acc_q2  <= 1'b0;
            load_q2 <= 1'b0;
        end else begin
            prod_q  <= prod_fmt;
            split_q <= (mode_q == MODE_DUAL);
            acc_q2  <= acc_q;
            load_q2 <= load_q;
        end
    end

    mac_accum #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .prod   (prod_q),
        .split  (split_q),
        .load   (load_q2),
        .acc_en (acc_q2),
        .acc    (result)
    );

    AST_CASC_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> casc_out == $past(a_sel)); // R4
    AST_SPLIT_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> split_q == ($past(mode_q) == MODE_DUAL)); // R6
    AST_LOAD_TWO_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && $past(rst_n) && $past(load, 2) |=> result == $past(prod_q)); // R12
endmodule

// File: tb/sim_mac_block.sv
`timescale 1ns/1ps
module sim_mac_block;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        pre_en = 1'b0, acc_en = 1'b0, load = 1'b0, casc_sel = 1'b0;
    logic [17:0] op_a = '0, op_b = '0, op_d = '0, casc_in = '0;
    logic [47:0] result;
    logic [17:0] casc_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mac_block u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .pre_en(pre_en),
        .acc_en(acc_en), .load(load), .casc_sel(casc_sel),
        .op_a(op_a), .op_b(op_b), .op_d(op_d), .casc_in(casc_in),
        .result(result), .casc_out(casc_out)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        pre;
        logic [17:0] a;
        logic [17:0] b;
        logic [17:0] d;
        logic [47:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 18'h00003, 18'h00005, 18'h00000, 48'h0000_0000_000F, 8'd2},  // R2
        '{2'd0, 1'b0, 18'h3FFFE, 18'h00007, 18'h00000, 48'hFFFF_FFFF_FFF2, 8'd2},  // R2 negative
        '{2'd0, 1'b1, 18'h1FFFF, 18'h00002, 18'h1FFFF, 48'h0000_0007_FFFC, 8'd3},  // R3 carry kept
        '{2'd0, 1'b1, 18'h20000, 18'h20000, 18'h20000, 48'h0008_0000_0000, 8'd3},  // R3 most negative
        '{2'd1, 1'b0, 18'h007FC, 18'h00A06, 18'h00000, 48'h00000F_FFFFE8, 8'd5},   // R5
        '{2'd2, 1'b0, 18'h007FC, 18'h00A06, 18'h00000, 48'hFFFF_FFFF_FFF7, 8'd7},  // R7
        '{2'd2, 1'b1, 18'h007FC, 18'h00A06, 18'h00300, 48'hFFFF_FFFF_F9FC, 8'd8},  // R8 dot
        '{2'd1, 1'b1, 18'h1FF00, 18'h1FF00, 18'h1FF00, 48'h01FC02_020000, 8'd8},   // R8 dual
        '{2'd3, 1'b0, 18'h00003, 18'h00005, 18'h00000, 48'h0000_0000_000F, 8'd13}  // R13
    };

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] m, input logic p, input logic [17:0] a,
                         input logic [17:0] b, input logic [17:0] d,
                         input logic ld, input logic en);
        mode = m; pre_en = p; op_a = a; op_b = b; op_d = d; load = ld; acc_en = en;
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs despite active inputs
        @(negedge clk);
        drive(2'd0, 1'b0, 18'h00005, 18'h00007, 18'h0, 1'b1, 1'b1);
        tick(3);
        check("R1 result", result, 48'h0);
        check("R1 casc_out", {30'h0, casc_out}, 48'h0);
        rst_n = 1'b1;

        // table walk: each vector loaded alone, read after three edges (R12)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].mode, VECS[i].pre, VECS[i].a, VECS[i].b, VECS[i].d, 1'b1, 1'b0);
            tick(3);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
        end

        // R12: latency, old value until third edge
        drive(2'd0, 1'b0, 18'h00003, 18'h00005, 18'h0, 1'b1, 1'b0);
        tick(3);
        drive(2'd0, 1'b0, 18'h00002, 18'h00002, 18'h0, 1'b1, 1'b0);
        tick(2);
        check("R12 before third edge", result, 48'd15);
        tick(1);
        check("R12 at third edge", result, 48'd4);

        // R4: cascade select and cascade output
        casc_sel = 1'b1; casc_in = 18'd11;
        drive(2'd0, 1'b0, 18'd99, 18'd3, 18'h0, 1'b1, 1'b0);
        tick(1);
        check("R4 casc_out from casc_in", {30'h0, casc_out}, 48'd11);
        tick(2);
        check("R4 product uses casc_in", result, 48'd33);
        casc_sel = 1'b0;
        tick(1);
        check("R4 casc_out from op_a", {30'h0, casc_out}, 48'd99);

        // R9: load wins over acc_en
        drive(2'd0, 1'b0, 18'd3, 18'd5, 18'h0, 1'b1, 1'b1);
        tick(4);
        check("R9 load precedence", result, 48'd15);

        // R2: accumulate, then R10 hold
        drive(2'd0, 1'b0, 18'd3, 18'd5, 18'h0, 1'b0, 1'b1);
        tick(4);
        check("R2 accumulate", result, 48'd45);
        acc_en = 1'b0;
        tick(3);
        check("R10 hold settle", result, 48'd75);
        tick(5);
        check("R10 hold", result, 48'd75);

        // R6: dual lanes, low half wraps without carry into high half
        drive(2'd1, 1'b1, 18'h00100, 18'h00100, 18'h00100, 1'b1, 1'b0);
        tick(3);
        check("R6 lane load", result, 48'h000000_020000);
        acc_en = 1'b1; load = 1'b0;
        tick(129);
        check("R6 no carry across lanes", result, 48'h0);
        acc_en = 1'b0;

        // R11: 48-bit wrap
        drive(2'd0, 1'b1, 18'h20000, 18'h20000, 18'h20000, 1'b1, 1'b0);
        tick(3);
        check("R11 load", result, 48'h0008_0000_0000);
        acc_en = 1'b1; load = 1'b0;
        tick(4098);
        check("R11 wrap", result, 48'h8008_0000_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule